// File: doc/BRIEF.md
# Interrupt Controller

This block gathers interrupt events for a small 8-bit microcontroller and turns them into one request line for the CPU core. It watches five sources: an overflow pulse from the first timer, an edge on an external interrupt pin, any change on the 8-bit port B, any change on the 8-bit port D, and an overflow pulse from the second timer. Each source has a flag bit and an enable bit held in registers that the CPU reaches over a simple read/write bus.

The enables form two levels. A global enable gates everything. Under it, the timer-0, external-pin and port-B sources are enabled one by one. The timer-1 and port-D sources sit behind a second, peripheral-group enable and have their own flag and enable registers. While the request is raised, the block presents the interrupt vector 0004h. The CPU acknowledges a request, which clears the global enable. A return-from-interrupt sets the global enable again. A port change whose individual enable is set also produces a one-cycle wake-up pulse, so a sleeping core can resume.

Top module: `irq_ctrl_top`

## Requirements
- R1: After synchronous reset the registers read as follows: control (address 0) 8'h01, peripheral flags 1 (address 1) 8'h00, peripheral flags 2 (address 2) 8'h80, peripheral enables 1 (address 3) 8'h00, peripheral enables 2 (address 4) 8'h00. irq_req_o is 0.
- R2: A one-cycle timer-0 overflow pulse sets control bit 2. A timer-1 overflow pulse sets bit 0 of peripheral flags 1. Each set is visible on the next cycle.
- R3: The external pin flag (control bit 1) is set on a rising edge of ext_pin_i when ext_rise_sel_i is 1, and on a falling edge when it is 0. The opposite edge leaves the flag unchanged.
- R4: The port-B change flag (control bit 0) is set while port_b_i differs from a stored copy. A read of address 5 returns port_b_i and reloads the copy. Port D works the same way with bit 7 of peripheral flags 2 and read address 6.
- R5: irq_req_o is 1 exactly when control bit 7 (global enable) is set and at least one of these holds: some pair of control flag and enable (bits 0/3, 1/4, 2/5) is set; or control bit 6 is set and a peripheral flag is set together with its enable.
- R6: irq_vec_o equals 13'h0004 while irq_req_o is 1, and 13'h0000 otherwise.
- R7: irq_ack_i clears control bit 7 on the next cycle. reti_i sets it, and reti_i wins over irq_ack_i and over a bus write.
- R8: A hardware flag set in the same cycle as a software write of 0 to that flag leaves the flag at 1.
- R9: wake_o pulses for one cycle after port B starts to differ from its copy while control bit 3 is set, or after port D starts to differ while bit 7 of peripheral enables 2 is set. This happens regardless of the global enable.
- R10: Unimplemented register bits read 0 even after 1s are written to them. Only bit 0 of the peripheral register 1 pair and bit 7 of the pair 2 are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe; on a port address, reloads that port's copy |
| rd_data_o | output | 8 | Read data (combinational) |
| tmr0_ovf_i | input | 1 | Timer-0 overflow pulse |
| tmr1_ovf_i | input | 1 | Timer-1 overflow pulse |
| ext_pin_i | input | 1 | External interrupt pin (synchronous) |
| ext_rise_sel_i | input | 1 | 1 selects rising edge, 0 selects falling edge |
| port_b_i | input | PORT_W | Port B input value |
| port_d_i | input | PORT_W | Port D input value |
| irq_ack_i | input | 1 | CPU accepts the interrupt |
| reti_i | input | 1 | Return-from-interrupt |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | VEC_W | Vector address |
| wake_o | output | 1 | Wake-up pulse from port change |

## Verification
The bench builds the block with its default parameters: 8-bit ports, a 3-bit address and a 13-bit vector with the interrupt vector at 0004h. With the full 8-bit port width, a single-bit change in a high port bit can be driven and observed through the read-back path, including the copy reload on a port read. With the default vector width, the exact vector value 0004h can be compared on every request.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int REG_W = 8;

    localparam logic [2:0] A_CTL   = 3'd0;
    localparam logic [2:0] A_PFLG1 = 3'd1;
    localparam logic [2:0] A_PFLG2 = 3'd2;
    localparam logic [2:0] A_PEN1  = 3'd3;
    localparam logic [2:0] A_PEN2  = 3'd4;
    localparam logic [2:0] A_PORTB = 3'd5;
    localparam logic [2:0] A_PORTD = 3'd6;

    // Main control register, MSB first so the packed layout matches bit order
    typedef struct packed {
        logic gie;
        logic peie;
        logic t0_en;
        logic ext_en;
        logic pb_en;
        logic t0_f;
        logic ext_f;
        logic pb_f;
    } ctl_reg_t;

    localparam ctl_reg_t CTL_RST = ctl_reg_t'(8'h01);

    // Flags in the single-bit peripheral register pairs
    typedef struct packed {
        logic t1_f;
        logic t1_en;
        logic pd_f;
        logic pd_en;
    } periph_t;

    localparam periph_t PERIPH_RST = '{t1_f: 1'b0, t1_en: 1'b0, pd_f: 1'b1, pd_en: 1'b0};

    function automatic logic main_pending(input ctl_reg_t c);
        return (c.t0_f & c.t0_en) | (c.ext_f & c.ext_en) | (c.pb_f & c.pb_en);
    endfunction

    function automatic logic periph_pending(input periph_t p);
        return (p.t1_f & p.t1_en) | (p.pd_f & p.pd_en);
    endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_i,
    input  logic rise_sel_i,
    output logic edge_o
);
    logic pin_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) pin_q <= pin_i;
        else       pin_q <= pin_i;
    end

    logic rise, fall;
    assign rise   = pin_i & ~pin_q;
    assign fall   = ~pin_i & pin_q;
    assign edge_o = rise_sel_i ? rise : fall;

    AST_EDGE_ON_CHANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        edge_o |-> (pin_i != $past(pin_i))); // R3

endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
    parameter int PORT_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic              reload_i,
    output logic              mismatch_o,
    output logic              rise_o
);
    logic [PORT_W-1:0] copy_q;
    logic              mis_prev_q;
    logic [PORT_W-1:0] diff;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            copy_q     <= port_i;
            mis_prev_q <= 1'b0;
        end else begin
            if (reload_i) copy_q <= port_i;
            mis_prev_q <= mismatch_o;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < PORT_W; gi++) begin : g_bit
            assign diff[gi] = port_i[gi] ^ copy_q[gi];
        end
    endgenerate

    assign mismatch_o = |diff;
    assign rise_o     = mismatch_o & ~mis_prev_q;

    AST_COPY_RELOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        reload_i |=> (copy_q == $past(port_i))); // R4

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int              VEC_W    = 13,
    parameter logic [VEC_W-1:0] INT_VEC  = VEC_W'(4),
    parameter logic [VEC_W-1:0] IDLE_VEC = '0
) (
    input  ctl_reg_t         ctl_i,
    input  periph_t          per_i,
    output logic             req_o,
    output logic [VEC_W-1:0] vec_o
);
    logic grp_main, grp_per;

    assign grp_main = main_pending(ctl_i);
    assign grp_per  = ctl_i.peie & periph_pending(per_i);
    assign req_o    = ctl_i.gie & (grp_main | grp_per);
    assign vec_o    = req_o ? INT_VEC : IDLE_VEC;

endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import irq_pkg::*;
#(
    parameter int               PORT_W   = 8,
    parameter int               ADDR_W   = 3,
    parameter int               VEC_W    = 13,
    parameter logic [VEC_W-1:0] INT_VEC  = VEC_W'(4),
    parameter logic [VEC_W-1:0] IDLE_VEC = '0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_data_i,
    input  logic              rd_en_i,
    output logic [7:0]        rd_data_o,
    input  logic              tmr0_ovf_i,
    input  logic              tmr1_ovf_i,
    input  logic              ext_pin_i,
    input  logic              ext_rise_sel_i,
    input  logic [PORT_W-1:0] port_b_i,
    input  logic [PORT_W-1:0] port_d_i,
    input  logic              irq_ack_i,
    input  logic              reti_i,
    output logic              irq_req_o,
    output logic [VEC_W-1:0]  irq_vec_o,
    output logic              wake_o
);
    localparam int AW = (ADDR_W < 3) ? ADDR_W : 3;

    ctl_reg_t ctl_q, ctl_d;
    periph_t  per_q, per_d;
    logic     wake_q;

    logic [2:0] sel;
    assign sel = 3'(addr_i[AW-1:0]);

    logic addr_hi_zero;
    generate
        if (ADDR_W > 3) begin : g_wide
            assign addr_hi_zero = ~|addr_i[ADDR_W-1:3];
        end else begin : g_narrow
            assign addr_hi_zero = 1'b1;
        end
    endgenerate

    logic wr_ctl, wr_pf1, wr_pf2, wr_pe1, wr_pe2, rd_pb, rd_pd;
    assign wr_ctl = wr_en_i & addr_hi_zero & (sel == A_CTL);
    assign wr_pf1 = wr_en_i & addr_hi_zero & (sel == A_PFLG1);
    assign wr_pf2 = wr_en_i & addr_hi_zero & (sel == A_PFLG2);
    assign wr_pe1 = wr_en_i & addr_hi_zero & (sel == A_PEN1);
    assign wr_pe2 = wr_en_i & addr_hi_zero & (sel == A_PEN2);
    assign rd_pb  = rd_en_i & addr_hi_zero & (sel == A_PORTB);
    assign rd_pd  = rd_en_i & addr_hi_zero & (sel == A_PORTD);

    // Event sources
    logic ext_evt, pb_mis, pb_rise, pd_mis, pd_rise;

    irq_edge_det u_ext (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .pin_i      (ext_pin_i),
        .rise_sel_i (ext_rise_sel_i),
        .edge_o     (ext_evt)
    );

    irq_port_watch #(.PORT_W(PORT_W)) u_pb (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .port_i     (port_b_i),
        .reload_i   (rd_pb),
        .mismatch_o (pb_mis),
        .rise_o     (pb_rise)
    );

    irq_port_watch #(.PORT_W(PORT_W)) u_pd (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .port_i     (port_d_i),
        .reload_i   (rd_pd),
        .mismatch_o (pd_mis),
        .rise_o     (pd_rise)
    );

    // Next-state: software write, then CPU handshakes, then hardware sets
    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctl) ctl_d = ctl_reg_t'(wr_data_i);
        if (irq_ack_i) ctl_d.gie = 1'b0;
        if (reti_i)    ctl_d.gie = 1'b1;
        ctl_d.t0_f  = ctl_d.t0_f  | tmr0_ovf_i;
        ctl_d.ext_f = ctl_d.ext_f | ext_evt;
        ctl_d.pb_f  = ctl_d.pb_f  | pb_mis;

        per_d = per_q;
        if (wr_pf1) per_d.t1_f  = wr_data_i[0];
        if (wr_pe1) per_d.t1_en = wr_data_i[0];
        if (wr_pf2) per_d.pd_f  = wr_data_i[7];
        if (wr_pe2) per_d.pd_en = wr_data_i[7];
        per_d.t1_f = per_d.t1_f | tmr1_ovf_i;
        per_d.pd_f = per_d.pd_f | pd_mis;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q  <= CTL_RST;
            per_q  <= PERIPH_RST;
            wake_q <= 1'b0;
        end else begin
            ctl_q  <= ctl_d;
            per_q  <= per_d;
            wake_q <= (pb_rise & ctl_q.pb_en) | (pd_rise & per_q.pd_en);
        end
    end

    irq_arbiter #(
        .VEC_W    (VEC_W),
        .INT_VEC  (INT_VEC),
        .IDLE_VEC (IDLE_VEC)
    ) u_arb (
        .ctl_i (ctl_q),
        .per_i (per_q),
        .req_o (irq_req_o),
        .vec_o (irq_vec_o)
    );

    assign wake_o = wake_q;

    // Read mux; unimplemented bits return zero
    always_comb begin
        rd_data_o = '0;
        if (addr_hi_zero) begin
            case (sel)
                A_CTL:   rd_data_o = ctl_q;
                A_PFLG1: rd_data_o = {7'b0, per_q.t1_f};
                A_PFLG2: rd_data_o = {per_q.pd_f, 7'b0};
                A_PEN1:  rd_data_o = {7'b0, per_q.t1_en};
                A_PEN2:  rd_data_o = {per_q.pd_en, 7'b0};
                A_PORTB: rd_data_o = 8'(port_b_i);
                A_PORTD: rd_data_o = 8'(port_d_i);
                default: rd_data_o = '0;
            endcase
        end
    end

    AST_ACK_CLEARS_GIE: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_ack_i && !reti_i) |=> !ctl_q.gie); // R7
    AST_RETI_SETS_GIE: assert property (@(posedge clk_i) disable iff (rst_i)
        reti_i |=> ctl_q.gie); // R7
    AST_T0_SET_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
        tmr0_ovf_i |=> ctl_q.t0_f); // R8
    AST_T1_SET_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
        tmr1_ovf_i |=> per_q.t1_f); // R2
    AST_WAKE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (rst_i)
        wake_o |-> $past(ctl_q.pb_en || per_q.pd_en)); // R9
    AST_REQ_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_ack_i && !reti_i) |=> !irq_req_o); // R5

endmodule

// File: tb/irq_ctrl_top_test.sv
module irq_ctrl_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  addr;
    logic        wr_en, rd_en;
    logic [7:0]  wr_data;
    logic [7:0]  rd_data;
    logic        tmr0, tmr1, ext, rise_sel, ack, reti;
    logic [7:0]  pb, pd;
    logic        req, wake;
    logic [12:0] vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    irq_ctrl_top uut (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .tmr0_ovf_i(tmr0), .tmr1_ovf_i(tmr1), .ext_pin_i(ext),
        .ext_rise_sel_i(rise_sel), .port_b_i(pb), .port_d_i(pd),
        .irq_ack_i(ack), .reti_i(reti), .irq_req_o(req),
        .irq_vec_o(vec), .wake_o(wake)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(3'd0, v); chk(16'(v), 16'h01, "R1 control");
        rd(3'd1, v); chk(16'(v), 16'h00, "R1 pflags1");
        rd(3'd2, v); chk(16'(v), 16'h80, "R1 pflags2");
        rd(3'd3, v); chk(16'(v), 16'h00, "R1 pen1");
        rd(3'd4, v); chk(16'(v), 16'h00, "R1 pen2");
        chk(16'(req), 16'h0, "R1 request");
        chk(16'(vec), 16'h0, "R6 idle vector");
        wr(3'd0, 8'h00); wr(3'd2, 8'h00);
        rd(3'd0, v); chk(16'(v), 16'h00, "R4 cleared control");
    endtask

    task automatic t_timer0();
        logic [7:0] v;
        wr(3'd0, 8'hA0);
        tmr0 = 1'b1; tick(); tmr0 = 1'b0;
        rd(3'd0, v); chk(16'(v), 16'hA4, "R2 t0 flag");
        chk(16'(req), 16'h1, "R5 t0 request");
        chk(16'(vec), 16'h0004, "R6 vector");
        ack = 1'b1; tick(); ack = 1'b0;
        rd(3'd0, v); chk(16'(v), 16'h24, "R7 ack clears gie");
        chk(16'(req), 16'h0, "R5 no request gie off");
        chk(16'(vec), 16'h0, "R6 vector idle");
        ack = 1'b1; reti = 1'b1; tick(); ack = 1'b0; reti = 1'b0;
        chk(16'(req), 16'h1, "R7 reti sets gie");
        wr(3'd0, 8'h80);
        chk(16'(req), 16'h0, "R5 flag cleared");
        // hardware set beats a software clear in the same cycle
        addr = 3'd0; wr_data = 8'h00; wr_en = 1'b1; tmr0 = 1'b1;
        tick(); wr_en = 1'b0; tmr0 = 1'b0;
        rd(3'd0, v); chk(16'(v), 16'h04, "R8 t0 set beats clear");
        wr(3'd0, 8'h80);
    endtask

    task automatic t_periph();
        logic [7:0] v;
        tmr1 = 1'b1; tick(); tmr1 = 1'b0;
        rd(3'd1, v); chk(16'(v), 16'h01, "R2 t1 flag");
        chk(16'(req), 16'h0, "R5 t1 not enabled");
        wr(3'd3, 8'h01);
        chk(16'(req), 16'h0, "R5 group enable off");
        wr(3'd0, 8'hC0);
        chk(16'(req), 16'h1, "R5 peripheral request");
        wr(3'd1, 8'h00);
        chk(16'(req), 16'h0, "R5 peripheral cleared");
        wr(3'd0, 8'h00); wr(3'd3, 8'h00);
    endtask

    task automatic t_ext();
        logic [7:0] v;
        rise_sel = 1'b1;
        ext = 1'b1; tick();
        rd(3'd0, v); chk(16'(v), 16'h02, "R3 rising edge");
        wr(3'd0, 8'h00);
        ext = 1'b0; tick();
        rd(3'd0, v); chk(16'(v), 16'h00, "R3 falling ignored");
        rise_sel = 1'b0; tick();
        ext = 1'b1; tick();
        rd(3'd0, v); chk(16'(v), 16'h00, "R3 rising ignored");
        ext = 1'b0; tick();
        rd(3'd0, v); chk(16'(v), 16'h02, "R3 falling edge");
        wr(3'd0, 8'h00);
    endtask

    task automatic t_ports();
        logic [7:0] v;
        pb = 8'h10; tick();
        rd(3'd0, v); chk(16'(v), 16'h01, "R4 port b change");
        wr(3'd0, 8'h00);
        rd(3'd0, v); chk(16'(v), 16'h01, "R8 mismatch beats clear");
        rd(3'd5, v); chk(16'(v), 16'h10, "R4 port b read");
        wr(3'd0, 8'h00);
        rd(3'd0, v); chk(16'(v), 16'h00, "R4 copy reloaded");
        pd = 8'h03; tick();
        rd(3'd2, v); chk(16'(v), 16'h80, "R4 port d change");
        rd(3'd6, v); chk(16'(v), 16'h03, "R4 port d read");
        wr(3'd2, 8'h00);
        rd(3'd2, v); chk(16'(v), 16'h00, "R4 port d cleared");
    endtask

    task automatic t_wake();
        logic [7:0] v;
        int seen;
        wr(3'd0, 8'h08);
        pb = 8'h11; tick();
        chk(16'(wake), 16'h1, "R9 wake port b");
        chk(16'(req), 16'h0, "R9 no request without gie");
        tick();
        chk(16'(wake), 16'h0, "R9 wake one cycle");
        rd(3'd5, v); wr(3'd0, 8'h00);
        pb = 8'h12;
        seen = 0;
        for (int i = 0; i < 3; i++) begin
            tick();
            if (wake) seen++;
        end
        chk(16'(seen), 16'h0, "R9 no wake when disabled");
        rd(3'd5, v); wr(3'd0, 8'h00);
        wr(3'd4, 8'h80);
        pd = 8'h07; tick();
        chk(16'(wake), 16'h1, "R9 wake port d");
        rd(3'd6, v); wr(3'd2, 8'h00); wr(3'd4, 8'h00);
    endtask

    task automatic t_unused();
        logic [7:0] v;
        wr(3'd1, 8'hFF); rd(3'd1, v); chk(16'(v), 16'h01, "R10 pflags1 bits");
        wr(3'd4, 8'hFF); rd(3'd4, v); chk(16'(v), 16'h80, "R10 pen2 bits");
        wr(3'd3, 8'hFE); rd(3'd3, v); chk(16'(v), 16'h00, "R10 pen1 bits");
        wr(3'd2, 8'h7F); rd(3'd2, v); chk(16'(v), 16'h00, "R10 pflags2 bits");
        wr(3'd1, 8'h00); wr(3'd4, 8'h00);
    endtask

    initial begin
        rst = 1'b1; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        tmr0 = 1'b0; tmr1 = 1'b0; ext = 1'b0; rise_sel = 1'b1;
        ack = 1'b0; reti = 1'b0; pb = '0; pd = '0;
        tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_timer0();
        t_periph();
        t_ext();
        t_ports();
        t_wake();
        t_unused();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule